// File: doc/BRIEF.md
# Clock Root Configuration Register Bank

This block is the control front end of a clock root generator. Software reaches five registers over a simple single-cycle register bus. These are a command register, a configuration register, and three counter registers: M, N and D. The configuration register selects the clock source, the counter mode and the half-integer pre-divider. Writes to the configuration and counter registers land only in shadow storage. The divider datapath and the source multiplexer see a separate active copy, which the block drives on its outputs.

Software applies the shadow values by setting the UPDATE bit in the command register. At that moment the block snapshots the shadow values. A fixed synchronisation delay later, it moves the snapshot into the active copy in one step and clears UPDATE on its own. Software polls UPDATE to learn that the change has finished. A dirty flag for each register shows which shadow values differ from what is running. The command register also holds a root enable request and a read-only root-off status bit.

Top module: `rcg_cfg_bank`

## Requirements
- R1: After reset all shadow and active values are zero and root enable is 0. The command register then reads 0x8000_0000.
- R2: The configuration register sits at offset 0x04. It reads back the pre-divider in bits [DIV_W-1:0], the source select in [10:8] and the counter mode in [13:12], with all other bits 0. M, N and D sit at offsets 0x08, 0x0C and 0x10 and read back their low MND_W bits.
- R3: A write to the configuration, M, N or D register changes only the shadow copy. The active outputs hold their values until a commit.
- R4: Writing 1 to command bit 0 (UPDATE) when no update is pending makes bit 0 read 1 from the next cycle on. Exactly two clock edges after the write edge, bit 0 reads 0 and the active outputs take the shadow values held at the write.
- R5: Command bits 4, 5, 6 and 7 are the dirty flags of the configuration, N, M and D registers. A flag sets when its register is written with a value that differs from the active copy. A write equal to the active copy leaves the flag clear.
- R6: When an update commits, each dirty flag clears unless its shadow value differs from the newly active value.
- R7: A write to a shadow register while an update is pending does not reach the active outputs at that commit. Its dirty flag stays set after the commit.
- R8: Command bit 1 is the root enable request. It drives `root_en` and reads back. Command bit 31 reads 1 whenever root enable is 0, and writes to it have no effect.
- R9: Writing UPDATE again while an update is pending neither restarts nor delays the commit.
- R10: A write to an unmapped address changes no register, and a read of one returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register bus and configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_addr | input | ADDR_W (5) | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| root_en | output | 1 | Root enable request to the clock gate |
| act_div | output | DIV_W (5) | Active half-integer pre-divider value |
| act_src | output | SRC_W (3) | Active source select |
| act_mode | output | 2 | Active counter mode |
| act_m | output | MND_W (8) | Active M value |
| act_n | output | MND_W (8) | Active N value |
| act_d | output | MND_W (8) | Active D value |

## Verification
The bench samples UPDATE and the active outputs one edge after the request, two edges after, and after the commit edge. A design that commits a cycle early or late, or lets the outputs drift before the commit, fails at one of those samples. Writes are placed inside the pending window to expose a design that copies live shadow values instead of the snapshot. A repeated UPDATE write in the same window catches a design that restarts its counter. Equal-value writes, writes to the read-only status bit and writes to an unmapped offset are followed by full readbacks. These catch flags that set on any write, status that software can overwrite, and decode that aliases.

// File: rtl/rcg_bank_pkg.sv
package rcg_bank_pkg;

  localparam int unsigned BUS_W = 32;

  // register byte offsets
  localparam int unsigned OFS_CMD = 'h00;
  localparam int unsigned OFS_CFG = 'h04;
  localparam int unsigned OFS_MND_BASE = 'h08;  // M, then N, then D, 4 apart

  // command register bit positions
  localparam int unsigned CMD_UPD_BIT   = 0;
  localparam int unsigned CMD_EN_BIT    = 1;
  localparam int unsigned CMD_DIRTY_LSB = 4;
  localparam int unsigned CMD_OFF_BIT   = 31;

  // configuration register field positions
  localparam int unsigned CFG_SRC_LSB  = 8;
  localparam int unsigned CFG_MODE_LSB = 12;
  localparam int unsigned MODE_W       = 2;

  // order of counter registers in the generated array
  typedef enum logic [1:0] {MND_M = 2'd0, MND_N = 2'd1, MND_D = 2'd2} mnd_idx_e;

endpackage

// File: rtl/rcg_update_seq.sv
module rcg_update_seq #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic upd_req,
  output logic busy,
  output logic snap,
  output logic commit
);
  localparam int unsigned CNT_W = (SYNC_STAGES > 1) ? $clog2(SYNC_STAGES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SYNC_STAGES - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign snap   = upd_req && !busy_q;
  assign commit = busy_q && (cnt_q == LAST);
  assign busy   = busy_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (snap) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (busy_q) begin
      if (commit) busy_d = 1'b0;
      else        cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  // R9: a pending update advances one step per cycle, never restarts
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !commit) |=> (busy_q && cnt_q == $past(cnt_q) + 1'b1));

  generate
    if (SYNC_STAGES >= 2) begin : g_len
      // R4: UPDATE stays visible for more than one cycle
      p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_q) |=> busy_q);
    end
  endgenerate

endmodule

// File: rtl/rcg_triple_reg.sv
module rcg_triple_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         snap,
  input  logic         commit,
  output logic [W-1:0] shadow_o,
  output logic [W-1:0] active_o,
  output logic         dirty_o
);
  logic [W-1:0] shadow_q, shadow_d;
  logic [W-1:0] staged_q, staged_d;
  logic [W-1:0] active_q, active_d;
  logic         dirty_q, dirty_d;

  always_comb begin
    shadow_d = wr_en  ? wr_data  : shadow_q;
    staged_d = snap   ? shadow_q : staged_q;
    active_d = commit ? staged_q : active_q;
    dirty_d  = dirty_q;
    if (commit)
      dirty_d = (shadow_d != staged_q);
    else if (wr_en && (wr_data != active_q))
      dirty_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      staged_q <= '0;
      active_q <= '0;
      dirty_q  <= 1'b0;
    end else begin
      shadow_q <= shadow_d;
      staged_q <= staged_d;
      active_q <= active_d;
      dirty_q  <= dirty_d;
    end
  end

  assign shadow_o = shadow_q;
  assign active_o = active_q;
  assign dirty_o  = dirty_q;

  // R3: active value only moves on a commit
  p_active_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(active_q));

  // R5: a differing write raises the flag
  p_dirty_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !commit && wr_data != active_q) |=> dirty_q);

  // R6: after a quiet commit the flag matches the real difference
  p_dirty_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !wr_en) |=> (dirty_q == (shadow_q != active_q)));

endmodule

// File: rtl/rcg_cfg_bank.sv
module rcg_cfg_bank
  import rcg_bank_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned DIV_W       = 5,
  parameter int unsigned SRC_W       = 3,
  parameter int unsigned MND_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  output logic [BUS_W-1:0]  reg_rdata,
  output logic              root_en,
  output logic [DIV_W-1:0]  act_div,
  output logic [SRC_W-1:0]  act_src,
  output logic [MODE_W-1:0] act_mode,
  output logic [MND_W-1:0]  act_m,
  output logic [MND_W-1:0]  act_n,
  output logic [MND_W-1:0]  act_d
);
  localparam int unsigned CFG_W = DIV_W + SRC_W + MODE_W;
  localparam int unsigned N_MND = 3;
  localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(OFS_CFG);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  // decode
  logic cmd_wr, cfg_wr;
  assign cmd_wr = reg_wr && (reg_addr == A_CMD);
  assign cfg_wr = reg_wr && (reg_addr == A_CFG);

  // update sequencer
  logic upd_busy, upd_snap, upd_commit;
  rcg_update_seq #(.SYNC_STAGES(SYNC_STAGES)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n_i),
    .upd_req(cmd_wr && reg_wdata[CMD_UPD_BIT]),
    .busy   (upd_busy),
    .snap   (upd_snap),
    .commit (upd_commit)
  );

  // root enable request
  logic root_en_q, root_en_d;
  always_comb root_en_d = cmd_wr ? reg_wdata[CMD_EN_BIT] : root_en_q;
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) root_en_q <= 1'b0;
    else          root_en_q <= root_en_d;
  end
  assign root_en = root_en_q;

  // configuration register: {mode, src, div}
  logic [CFG_W-1:0] cfg_wval, cfg_shadow, cfg_active;
  logic             cfg_dirty;
  assign cfg_wval = {reg_wdata[CFG_MODE_LSB +: MODE_W],
                     reg_wdata[CFG_SRC_LSB +: SRC_W],
                     reg_wdata[DIV_W-1:0]};

  rcg_triple_reg #(.W(CFG_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .wr_en   (cfg_wr),
    .wr_data (cfg_wval),
    .snap    (upd_snap),
    .commit  (upd_commit),
    .shadow_o(cfg_shadow),
    .active_o(cfg_active),
    .dirty_o (cfg_dirty)
  );

  // counter registers M, N, D
  logic [MND_W-1:0] mnd_shadow [N_MND];
  logic [MND_W-1:0] mnd_active [N_MND];
  logic [N_MND-1:0] mnd_dirty;
  logic [N_MND-1:0] mnd_hit;

  generate
    for (genvar g = 0; g < N_MND; g++) begin : g_mnd
      localparam logic [ADDR_W-1:0] A_REG = ADDR_W'(OFS_MND_BASE + 4 * g);
      assign mnd_hit[g] = (reg_addr == A_REG);
      rcg_triple_reg #(.W(MND_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n_i),
        .wr_en   (reg_wr && mnd_hit[g]),
        .wr_data (reg_wdata[MND_W-1:0]),
        .snap    (upd_snap),
        .commit  (upd_commit),
        .shadow_o(mnd_shadow[g]),
        .active_o(mnd_active[g]),
        .dirty_o (mnd_dirty[g])
      );
    end
  endgenerate

  // active outputs
  assign act_div  = cfg_active[DIV_W-1:0];
  assign act_src  = cfg_active[DIV_W +: SRC_W];
  assign act_mode = cfg_active[DIV_W+SRC_W +: MODE_W];
  assign act_m    = mnd_active[MND_M];
  assign act_n    = mnd_active[MND_N];
  assign act_d    = mnd_active[MND_D];

  // read mux
  logic [3:0] dirty_bits;
  assign dirty_bits = {mnd_dirty[MND_D], mnd_dirty[MND_M], mnd_dirty[MND_N], cfg_dirty};

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == A_CMD) begin
      reg_rdata[CMD_UPD_BIT]          = upd_busy;
      reg_rdata[CMD_EN_BIT]           = root_en_q;
      reg_rdata[CMD_DIRTY_LSB +: 4]   = dirty_bits;
      reg_rdata[CMD_OFF_BIT]          = !root_en_q;
    end else if (reg_addr == A_CFG) begin
      reg_rdata[DIV_W-1:0]            = cfg_shadow[DIV_W-1:0];
      reg_rdata[CFG_SRC_LSB +: SRC_W] = cfg_shadow[DIV_W +: SRC_W];
      reg_rdata[CFG_MODE_LSB +: MODE_W] = cfg_shadow[DIV_W+SRC_W +: MODE_W];
    end else begin
      for (int i = 0; i < N_MND; i++)
        if (mnd_hit[i]) reg_rdata[MND_W-1:0] = mnd_shadow[i];
    end
  end

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^reg_wdata;

  // R8: root enable only rises through a command write
  p_root_en_src_r8: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(root_en_q) |-> $past(cmd_wr));

  // R4: active configuration never changes while no update is pending
  p_cfg_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!upd_busy && !upd_snap) |=> $stable(cfg_active));

endmodule

// File: tb/sim_rcg_cfg_bank.sv
module sim_rcg_cfg_bank;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 5000;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        root_en;
  logic [4:0]  act_div;
  logic [2:0]  act_src;
  logic [1:0]  act_mode;
  logic [7:0]  act_m, act_n, act_d;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  rcg_cfg_bank u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .root_en(root_en),
    .act_div(act_div), .act_src(act_src), .act_mode(act_mode),
    .act_m(act_m), .act_n(act_n), .act_d(act_d)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // write, returns at the falling edge after the capturing edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(5'h00, v); chk("R1 cmd", v, 32'h8000_0000);
    rd(5'h04, v); chk("R1 cfg", v, 0);
    rd(5'h08, v); chk("R1 m", v, 0);
    rd(5'h10, v); chk("R1 d", v, 0);
    chk("R1 actives", {act_div, act_src, act_mode, act_m, act_n, act_d, root_en}, 0);
  endtask

  task automatic t_readback;
    logic [31:0] v;
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, v); chk("R2 cfg fields", v, 32'h0000_371F);
    wr(5'h08, 32'h0000_01A5);
    rd(5'h08, v); chk("R2 m width", v, 32'h0000_00A5);
    chk("R3 actives untouched", {act_div, act_src, act_mode, act_m}, 0);
    rd(5'h00, v); chk("R5 dirty cfg and m", v, 32'h8000_0050);
  endtask

  task automatic t_commit;
    logic [31:0] v;
    wr(5'h0C, 32'h33);
    wr(5'h10, 32'h44);
    rd(5'h0C, v); chk("R2 n readback", v, 32'h33);
    rd(5'h00, v); chk("R5 all dirty", v, 32'h8000_00F1 & 32'hFFFF_FFF0);
    wr(5'h00, 32'h1);
    rd(5'h00, v); chk("R4 update set", v[0], 1);
    chk("R4 not yet active", act_m, 0);
    @(negedge clk);
    rd(5'h00, v); chk("R4 still pending", v[0], 1);
    chk("R3 hold while pending", act_n, 0);
    @(negedge clk);
    rd(5'h00, v); chk("R4 update cleared", v[0], 0);
    chk("R4 cfg active", {act_div, act_src, act_mode}, {5'h1F, 3'h7, 2'h3});
    chk("R4 mnd active", {act_m, act_n, act_d}, 24'hA5_33_44);
    chk("R6 dirty cleared", v, 32'h8000_0000);
  endtask

  task automatic t_equal_write;
    logic [31:0] v;
    wr(5'h08, 32'hA5);
    rd(5'h00, v); chk("R5 equal write leaves clean", v, 32'h8000_0000);
    wr(5'h08, 32'h10);
    rd(5'h00, v); chk("R5 m dirty", v, 32'h8000_0040);
  endtask

  task automatic t_window;
    logic [31:0] v;
    wr(5'h00, 32'h1);
    wr(5'h10, 32'h99);
    @(negedge clk);
    chk("R7 m committed", act_m, 8'h10);
    chk("R7 d held back", act_d, 8'h44);
    rd(5'h00, v); chk("R7 d dirty after commit", v, 32'h8000_0080);
  endtask

  task automatic t_retrigger;
    logic [31:0] v;
    wr(5'h00, 32'h1);
    wr(5'h00, 32'h1);
    @(negedge clk);
    rd(5'h00, v); chk("R9 no restart", v[0], 0);
    chk("R9 commit on time", act_d, 8'h99);
    chk("R6 clean after commit", v, 32'h8000_0000);
  endtask

  task automatic t_root;
    logic [31:0] v;
    wr(5'h00, 32'h2);
    rd(5'h00, v); chk("R8 enabled", v, 32'h0000_0002);
    chk("R8 root_en pin", root_en, 1);
    wr(5'h00, 32'h8000_0002);
    rd(5'h00, v); chk("R8 status read only", v, 32'h0000_0002);
    wr(5'h00, 32'h0);
    rd(5'h00, v); chk("R8 disabled", v, 32'h8000_0000);
    chk("R8 root_en low", root_en, 0);
  endtask

  task automatic t_unmapped;
    logic [31:0] v;
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h02, 32'hFFFF_FFFF);
    rd(5'h14, v); chk("R10 read zero", v, 0);
    rd(5'h04, v); chk("R10 cfg intact", v, 32'h0000_371F);
    rd(5'h08, v); chk("R10 m intact", v, 32'h10);
    rd(5'h10, v); chk("R10 d intact", v, 32'h99);
    rd(5'h00, v); chk("R10 cmd intact", v, 32'h8000_0000);
  endtask

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_readback;
    t_commit;
    t_equal_write;
    t_window;
    t_retrigger;
    t_root;
    t_unmapped;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule